// File: doc/BRIEF.md
# Arrival-Order Shared Port Arbiter

This block decides which of sixteen requesters may use a single shared memory port in each access window. It does not step through requesters in a fixed rotation. It grants them in the order their requests arrived. A requester raises its request line and keeps it high. The block records the requester's index in a circular queue. Each time the window strobe is high and the queue holds an entry, the oldest index leaves the queue, and that requester receives a one-cycle grant in the next clock cycle. On an idle system, the next window goes straight to the first new requester, with no wait for a position to come round.

When several requesters raise their lines in the same cycle, they are all queued in that cycle, in ascending index order. The tail can therefore move by up to sixteen places at once. Each requester holds at most one queue entry at a time, so sixteen entries are always enough. The data path and the memory itself sit outside the block. The handshake is a plain level request answered by a grant pulse, with no ready or valid signals. A requester must drop its request in the cycle its grant is high. If it keeps the request high through that cycle, it rejoins the queue at the tail.

Top module: `fifo_grant_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant_o` is all zero and `q_empty_o` is 1.
- R2: A request that is high in a cycle before a window cycle is granted by that window: bit k of `grant_o` rises in the cycle after the window cycle. A request first raised in the window cycle itself is not served by that window. It is served by the following window.
- R3: Requests raised in different cycles are granted in the order of the cycles they were raised in.
- R4: Requests first raised in the same cycle are granted in ascending index order, bit 0 first.
- R5: A requester that holds its request high while already queued gets exactly one entry. After it is granted and drops its request, it receives no further grant.
- R6: `grant_o` has at most one bit set. A grant lasts exactly one clock cycle, and a grant appears only in the cycle after a window cycle.
- R7: A window cycle with an empty queue produces no grant.
- R8: Every window cycle in which the queue is non-empty produces a grant in the next cycle, so windows held high back to back grant one requester per cycle.
- R9: A requester whose request is still high in the cycle its grant is high is queued again behind every entry already in the queue.
- R10: When all sixteen requesters ask in the same cycle, each one is granted within sixteen windows, and the queue never holds more than sixteen entries.
- R11: `q_empty_o` is 1 exactly when no requester is queued. It goes low in the cycle after a request is taken in, and it goes high in the cycle after the last entry is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Request level per requester, bit k for requester k |
| window_i | input | 1 | High in a cycle that is an access window for the shared port |
| grant_o | output | 16 | One-hot grant pulse, one cycle after the window that served it |
| q_empty_o | output | 1 | High when the queue holds no requester |

## Verification
The assertions assume that requesters follow the handshake: each requester holds its request until granted and drops it in the grant cycle, unless the scenario deliberately tests re-queuing. They also assume that the queue can never be asked to hold more than one entry per requester. The bench drives requests and the window strobe only on falling edges. It releases each request in the cycle its grant is seen. Only the re-queue scenario keeps one request high through its grant cycle. Under these conditions the overflow, underflow and grant-of-pending properties cover every reachable state.

// File: rtl/fga_pkg.sv
package fga_pkg;
  localparam int unsigned FGA_REQ_DEF = 16;

  function automatic int unsigned fga_cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fga_arrival_rank.sv
// Gives every newly arriving requester its slot offset behind the tail:
// the number of new requesters with a lower index.
module fga_arrival_rank import fga_pkg::*; #(
  parameter int unsigned N_REQ = FGA_REQ_DEF,
  localparam int unsigned CW = fga_cnt_w(N_REQ)
) (
  input  logic [N_REQ-1:0]         new_vec,
  output logic [N_REQ-1:0][CW-1:0] slot_ofs,
  output logic [CW-1:0]            new_cnt
);
  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N_REQ; i++) begin
      slot_ofs[i] = acc;
      acc = acc + CW'(new_vec[i]);
    end
    new_cnt = acc;
  end
endmodule

// File: rtl/fga_pending.sv
// Tracks which requesters already hold a queue entry.
module fga_pending import fga_pkg::*; #(
  parameter int unsigned N_REQ = FGA_REQ_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic [N_REQ-1:0] clr_vec,
  output logic [N_REQ-1:0] new_vec,
  output logic [N_REQ-1:0] pending
);
  assign new_vec = req & ~pending;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= '0;
    else        pending <= (pending | new_vec) & ~clr_vec;
  end

  // R5
  grant_was_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec & ~pending) == '0);
endmodule

// File: rtl/fga_id_queue.sv
// Circular index queue with multi-entry push and single pop per cycle.
module fga_id_queue import fga_pkg::*; #(
  parameter int unsigned N_REQ   = FGA_REQ_DEF,
  parameter int unsigned Q_DEPTH = N_REQ,
  localparam int unsigned IDW  = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int unsigned CW   = fga_cnt_w(N_REQ),
  localparam int unsigned PW   = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1,
  localparam int unsigned CNTW = fga_cnt_w(Q_DEPTH),
  localparam int unsigned SW   = ((CW > PW) ? CW : PW) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_REQ-1:0]         push_vec,
  input  logic [N_REQ-1:0][CW-1:0] push_ofs,
  input  logic [CW-1:0]            push_cnt,
  input  logic                     pop,
  output logic [IDW-1:0]           head_id,
  output logic                     empty
);
  logic [IDW-1:0]  mem [Q_DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count_q;
  logic [PW-1:0]   wr_idx [N_REQ];
  logic [PW-1:0]   wr_ptr_nx;

  always_comb begin
    for (int i = 0; i < N_REQ; i++) begin
      logic [SW-1:0] s;
      s = SW'(wr_ptr) + SW'(push_ofs[i]);
      if (s >= SW'(Q_DEPTH)) s = s - SW'(Q_DEPTH);
      wr_idx[i] = PW'(s);
    end
  end

  always_comb begin
    logic [SW-1:0] t;
    t = SW'(wr_ptr) + SW'(push_cnt);
    if (t >= SW'(Q_DEPTH)) t = t - SW'(Q_DEPTH);
    wr_ptr_nx = PW'(t);
  end

  assign head_id = mem[rd_ptr];
  assign empty   = (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      for (int j = 0; j < Q_DEPTH; j++) mem[j] <= '0;
    end else begin
      for (int i = 0; i < N_REQ; i++)
        if (push_vec[i]) mem[wr_idx[i]] <= IDW'(i);
      wr_ptr  <= wr_ptr_nx;
      if (pop) rd_ptr <= (rd_ptr == PW'(Q_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count_q <= count_q + CNTW'(push_cnt) - CNTW'(pop);
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count_q) + int'(push_cnt) - int'(pop)) <= int'(Q_DEPTH));
  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/fifo_grant_arbiter.sv
module fifo_grant_arbiter import fga_pkg::*; #(
  parameter int unsigned N_REQ   = FGA_REQ_DEF,
  parameter int unsigned Q_DEPTH = N_REQ
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic             window_i,
  output logic [N_REQ-1:0] grant_o,
  output logic             q_empty_o
);
  localparam int unsigned IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam int unsigned CW  = fga_cnt_w(N_REQ);

  logic [N_REQ-1:0]         new_vec, pending, grant_nx;
  logic [N_REQ-1:0][CW-1:0] slot_ofs;
  logic [CW-1:0]            new_cnt;
  logic [IDW-1:0]           head_id;
  logic                     q_empty, pop;

  fga_pending #(.N_REQ(N_REQ)) u_pending (
    .clk(clk), .rst_n(rst_n), .req(req_i), .clr_vec(grant_nx),
    .new_vec(new_vec), .pending(pending)
  );

  fga_arrival_rank #(.N_REQ(N_REQ)) u_rank (
    .new_vec(new_vec), .slot_ofs(slot_ofs), .new_cnt(new_cnt)
  );

  fga_id_queue #(.N_REQ(N_REQ), .Q_DEPTH(Q_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push_vec(new_vec), .push_ofs(slot_ofs),
    .push_cnt(new_cnt), .pop(pop), .head_id(head_id), .empty(q_empty)
  );

  assign pop = window_i & ~q_empty;

  always_comb begin
    for (int i = 0; i < N_REQ; i++)
      grant_nx[i] = pop && (head_id == IDW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) grant_o <= '0;
    else        grant_o <= grant_nx;
  end

  assign q_empty_o = q_empty;

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  // R6
  no_window_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !window_i |=> (grant_o == '0));
  // R7
  empty_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty_o |=> (grant_o == '0));
  // R8
  window_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (window_i && !q_empty_o) |=> (grant_o != '0));
  // R5
  grant_from_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_nx & ~pending) == '0);
endmodule

// File: tb/test_fifo_grant_arbiter.sv
`timescale 1ns/1ps
module test_fifo_grant_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        window = 1'b0;
  logic [15:0] grant;
  logic        q_empty;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  fifo_grant_arbiter i_fifo_grant_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .window_i(window),
    .grant_o(grant), .q_empty_o(q_empty)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one-cycle window; returns grant seen in the following cycle
  task automatic open_window(input bit keep_req, output logic [15:0] g);
    window = 1'b1;
    tick();
    window = 1'b0;
    g = grant;
    if (!keep_req) req = req & ~g;
  endtask

  task automatic expect_grant(input int id, input string tag);
    logic [15:0] g;
    open_window(1'b0, g);
    check(g == (16'h1 << id), tag, g, 16'h1 << id);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    check(grant == '0, "R1 grant in reset", grant, '0);
    check(q_empty == 1'b1, "R1 empty in reset", 16'(q_empty), 16'h1);
    rst_n = 1'b1;
    tick();
    check(grant == '0 && q_empty, "R1 after reset", grant, '0);
  endtask

  task automatic t_empty_window();
    logic [15:0] g;
    open_window(1'b0, g);
    check(g == '0, "R7 window on empty queue", g, '0);
  endtask

  task automatic t_single();
    req[5] = 1'b1;
    window = 1'b1;
    tick();
    check(grant == '0, "R2 same-cycle request not served", grant, '0);
    check(q_empty == 1'b0, "R11 empty drops after request", 16'(q_empty), '0);
    tick();
    check(grant == 16'h0020, "R2 granted by next window", grant, 16'h0020);
    window = 1'b0;
    req = req & ~grant;
    tick();
    check(grant == '0, "R6 grant lasts one cycle", grant, '0);
    check(q_empty == 1'b1, "R11 empty after last grant", 16'(q_empty), 16'h1);
  endtask

  task automatic t_arrival_order();
    req[9] = 1'b1; tick();
    req[2] = 1'b1; tick();
    req[12] = 1'b1; tick();
    expect_grant(9, "R3 first arrival");
    expect_grant(2, "R3 second arrival");
    expect_grant(12, "R3 third arrival");
    check(q_empty == 1'b1, "R11 empty after drain", 16'(q_empty), 16'h1);
  endtask

  task automatic t_simultaneous();
    req = 16'h408A; // ids 1,3,7,14
    tick();
    expect_grant(1, "R4 ascending 1");
    expect_grant(3, "R4 ascending 3");
    expect_grant(7, "R4 ascending 7");
    expect_grant(14, "R4 ascending 14");
  endtask

  task automatic t_mixed();
    req[10] = 1'b1; tick();
    req[15] = 1'b1; req[0] = 1'b1; tick();
    expect_grant(10, "R3 older before newer group");
    expect_grant(0, "R4 group low id first");
    expect_grant(15, "R4 group high id last");
  endtask

  task automatic t_held();
    logic [15:0] g;
    req[4] = 1'b1;
    repeat (3) tick();
    req[6] = 1'b1;
    repeat (2) tick();
    expect_grant(4, "R5 held request granted once");
    expect_grant(6, "R5 later requester next");
    open_window(1'b0, g);
    check(g == '0, "R5 no duplicate entry", g, '0);
  endtask

  task automatic t_requeue();
    logic [15:0] g;
    req[8] = 1'b1; req[11] = 1'b1;
    tick();
    open_window(1'b1, g);
    check(g == 16'h0100, "R9 first grant 8", g, 16'h0100);
    tick();
    req[8] = 1'b0;
    expect_grant(11, "R9 waiting entry first");
    expect_grant(8, "R9 re-queued at tail");
    check(q_empty == 1'b1, "R9 queue drained", 16'(q_empty), 16'h1);
  endtask

  task automatic t_all();
    req = 16'hFFFF;
    tick();
    window = 1'b1;
    for (int k = 0; k < 16; k++) begin
      tick();
      check(grant == (16'h1 << k), "R10 R8 back-to-back order", grant, 16'h1 << k);
      req = req & ~grant;
    end
    check(q_empty == 1'b1, "R10 empty after sixteen", 16'(q_empty), 16'h1);
    tick();
    check(grant == '0, "R7 window after drain", grant, '0);
    window = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_empty_window();
    t_single();
    t_arrival_order();
    t_simultaneous();
    t_mixed();
    t_held();
    t_requeue();
    t_all();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule